// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block turns up to 32 already-filtered input pin levels into interrupt events. For each pin, software chooses level or edge sensing, which level or edge is active, and whether any transition at all should count. Level conditions are reported as they stand on every cycle. Edge conditions are caught in a sticky per-pin bit that stays set until software acknowledges it.

The block offers two status views. The raw view shows every pending pin, masked or not. The masked view hides the pins that software has masked. The OR of the masked view is registered and sent out as a single interrupt request.

All per-pin registers are 32 bits wide and are reached as two 16-bit halves. Each write carries its own per-bit write enables, so software can change single bits without a read-modify-write. Reads are combinational from the address.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every configuration register reads 0, both status views read 0 and `irq_o` is low.
- R2: A register at offset A holds bits 15:0, and offset A+4 holds bits 31:16. In a write word, bits 15:0 are the new values and bits 31:16 are per-bit write enables; a bit whose enable is 0 keeps its old value. A read returns the half in bits 15:0, with zeros above. Offsets: enable 0x10, mask 0x18, type 0x20, polarity 0x28, any-edge 0x30, masked status 0x50, raw status 0x58, acknowledge 0x60.
- R3: With type 0 (level sensing) and the any-edge bit 0, a pin's raw bit is 1 exactly while the pin is enabled and its level equals its polarity bit (1 = high, 0 = low). The bit follows the pin in the same cycle and is not held.
- R4: With type 1 (edge sensing), polarity 1 catches a rising edge and polarity 0 catches a falling edge. The raw bit is set at the first clock edge that sees the transition and stays set. The opposite edge, or any edge on a disabled pin, sets nothing.
- R5: With the any-edge bit 1, both rising and falling transitions set the sticky raw bit, whatever the type and polarity bits hold.
- R6: The masked status equals raw status AND NOT mask. A masked pin still shows in the raw status.
- R7: Writing 1, with its enable set, to a pin's bit in the acknowledge register clears that pin's sticky edge bit. Bits written with enable 0 are untouched. The register reads as 0.
- R8: If an active edge and its acknowledge occur in the same cycle, the sticky bit ends up set.
- R9: `irq_o` is the OR of the masked status, delayed by one clock.
- R10: The start-up order — mask all, acknowledge all, then enable all — raises no request while every pin stays masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | NPINS | Filtered pin levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Write word: enables in 31:16, values in 15:0 |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two events can meet in one cycle: the setting of a sticky edge bit and its clearing by an acknowledge write. The bench provokes this by changing the pin in the same cycle as the acknowledge write. It expects the raw bit to read 1 afterwards and the request to rise one cycle later. A second, standalone acknowledge must then clear the bit. The inverse case, an acknowledge whose enables are zero, is judged by reading the raw bit back unchanged.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int REG_W   = 32;
    localparam int HALF_W  = REG_W / 2;
    localparam int HI_STEP = 4;

    localparam int OFS_EN    = 'h10;
    localparam int OFS_MASK  = 'h18;
    localparam int OFS_TYPE  = 'h20;
    localparam int OFS_POL   = 'h28;
    localparam int OFS_ANY   = 'h30;
    localparam int OFS_MSTAT = 'h50;
    localparam int OFS_RAW   = 'h58;
    localparam int OFS_ACK   = 'h60;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [NPINS-1:0]  en_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  type_o,
    output logic [NPINS-1:0]  pol_o,
    output logic [NPINS-1:0]  any_o,
    output logic [NPINS-1:0]  ack_o
);
    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] msk;
        logic [NPINS-1:0] typ;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] any;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [REG_W-1:0] ack_we, ack_val;

    // Place the 16 enable bits of the word in the addressed half.
    function automatic logic [REG_W-1:0] lane_we(input logic [ADDR_W-1:0] a,
                                                 input int base,
                                                 input logic [REG_W-1:0] wd);
        logic [REG_W-1:0] r;
        r = '0;
        if (a == ADDR_W'(base))
            r[HALF_W-1:0] = wd[REG_W-1:HALF_W];
        else if (a == ADDR_W'(base + HI_STEP))
            r[REG_W-1:HALF_W] = wd[REG_W-1:HALF_W];
        return r;
    endfunction

    // Place the 16 value bits of the word in the addressed half.
    function automatic logic [REG_W-1:0] lane_val(input logic [ADDR_W-1:0] a,
                                                  input int base,
                                                  input logic [REG_W-1:0] wd);
        logic [REG_W-1:0] r;
        r = '0;
        if (a == ADDR_W'(base))
            r[HALF_W-1:0] = wd[HALF_W-1:0];
        else if (a == ADDR_W'(base + HI_STEP))
            r[REG_W-1:HALF_W] = wd[HALF_W-1:0];
        return r;
    endfunction

    function automatic logic [NPINS-1:0] merge(input logic [NPINS-1:0] cur,
                                               input logic [REG_W-1:0] we,
                                               input logic [REG_W-1:0] val);
        return (cur & ~we[NPINS-1:0]) | (val[NPINS-1:0] & we[NPINS-1:0]);
    endfunction

    always_comb begin
        cfg_d   = cfg_q;
        ack_we  = '0;
        ack_val = '0;
        if (wr_i) begin
            cfg_d.en  = merge(cfg_q.en,  lane_we(addr_i, OFS_EN,   wdata_i), lane_val(addr_i, OFS_EN,   wdata_i));
            cfg_d.msk = merge(cfg_q.msk, lane_we(addr_i, OFS_MASK, wdata_i), lane_val(addr_i, OFS_MASK, wdata_i));
            cfg_d.typ = merge(cfg_q.typ, lane_we(addr_i, OFS_TYPE, wdata_i), lane_val(addr_i, OFS_TYPE, wdata_i));
            cfg_d.pol = merge(cfg_q.pol, lane_we(addr_i, OFS_POL,  wdata_i), lane_val(addr_i, OFS_POL,  wdata_i));
            cfg_d.any = merge(cfg_q.any, lane_we(addr_i, OFS_ANY,  wdata_i), lane_val(addr_i, OFS_ANY,  wdata_i));
            ack_we    = lane_we(addr_i, OFS_ACK, wdata_i);
            ack_val   = lane_val(addr_i, OFS_ACK, wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o   = cfg_q.en;
    assign mask_o = cfg_q.msk;
    assign type_o = cfg_q.typ;
    assign pol_o  = cfg_q.pol;
    assign any_o  = cfg_q.any;
    assign ack_o  = ack_we[NPINS-1:0] & ack_val[NPINS-1:0];

    // R2: a write whose enable half is all zero changes no configuration bit
    a_r2_no_enable_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (wdata_i[REG_W-1:HALF_W] == '0)) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] en_i,
    input  logic [NPINS-1:0] type_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] any_i,
    input  logic [NPINS-1:0] ack_i,
    output logic [NPINS-1:0] raw_o
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] sticky;
    } det_t;

    det_t st_d, st_q;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] lvl;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall;
        assign rise   = pin_i[i] & ~st_q.prev[i];
        assign fall   = ~pin_i[i] & st_q.prev[i];
        assign hit[i] = en_i[i] & (any_i[i] ? (rise | fall)
                                            : (type_i[i] & (pol_i[i] ? rise : fall)));
        assign lvl[i] = en_i[i] & ~type_i[i] & ~any_i[i] & (pin_i[i] == pol_i[i]);
        assign raw_o[i] = (type_i[i] | any_i[i]) ? st_q.sticky[i] : lvl[i];
    end

    always_comb begin
        st_d        = st_q;
        st_d.prev   = pin_i;
        st_d.sticky = (st_q.sticky & ~ack_i) | hit;   // set beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a sticky bit only drops on a cycle that acknowledged it
    a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q.sticky) & ~$past(ack_i)) & ~st_q.sticky) == '0));

    // R8: an edge meeting its acknowledge leaves the bit set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit & ack_i) & ~st_q.sticky) == '0));

    // R4: no sticky bit rises on a pin that was disabled
    a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sticky & ~$past(st_q.sticky) & ~$past(en_i)) == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic irq;
    } top_t;

    top_t top_d, top_q;
    logic [NPINS-1:0] en, msk, typ, pol, any, ack, raw, mstat;

    gpio_irq_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W)) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr_i),
        .addr_i (reg_addr_i),
        .wdata_i(reg_wdata_i),
        .en_o   (en),
        .mask_o (msk),
        .type_o (typ),
        .pol_o  (pol),
        .any_o  (any),
        .ack_o  (ack)
    );

    gpio_irq_detect #(.NPINS(NPINS)) det_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .en_i  (en),
        .type_i(typ),
        .pol_i (pol),
        .any_i (any),
        .ack_i (ack),
        .raw_o (raw)
    );

    assign mstat = raw & ~msk;

    function automatic logic [REG_W-1:0] rd_sel(input logic [ADDR_W-1:0] a,
                                                input int base,
                                                input logic [REG_W-1:0] v);
        if (a == ADDR_W'(base))
            return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
        if (a == ADDR_W'(base + HI_STEP))
            return {{HALF_W{1'b0}}, v[REG_W-1:HALF_W]};
        return '0;
    endfunction

    always_comb begin
        reg_rdata_o = rd_sel(reg_addr_i, OFS_EN,    REG_W'(en))
                    | rd_sel(reg_addr_i, OFS_MASK,  REG_W'(msk))
                    | rd_sel(reg_addr_i, OFS_TYPE,  REG_W'(typ))
                    | rd_sel(reg_addr_i, OFS_POL,   REG_W'(pol))
                    | rd_sel(reg_addr_i, OFS_ANY,   REG_W'(any))
                    | rd_sel(reg_addr_i, OFS_MSTAT, REG_W'(mstat))
                    | rd_sel(reg_addr_i, OFS_RAW,   REG_W'(raw));
    end

    always_comb begin
        top_d     = top_q;
        top_d.irq = |mstat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign irq_o = top_q.irq;

    // R6 / R10: with every pin masked, no request follows
    a_r6_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&msk) |=> !irq_o);
endmodule

// File: tb/gpio_irq_unit_tb_top.sv
`timescale 1ns/10ps
module gpio_irq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        logic [31:0] care;
        string       tag;
    } item_t;
    item_t sb[$];
    event  smp_ev;

    always #10 clk = ~clk;

    gpio_irq_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pins),
        .reg_wr_i   (reg_wr),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .irq_o      (irq)
    );

    // Monitor: pops expected items and compares with the design's outputs.
    initial begin
        forever begin
            @(smp_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = (it.kind == 0) ? reg_rdata : {31'b0, irq};
                checks++;
                if ((act & it.care) != (it.exp & it.care)) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act & it.care, it.exp & it.care);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] w);
        reg_addr  = a;
        reg_wdata = w;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input logic [31:0] care, input string tag);
        item_t it;
        reg_addr = a;
        #0.2;
        it = '{0, exp, care, tag};
        sb.push_back(it);
        ->smp_ev;
        #0.2;
    endtask

    task automatic irqc(input logic exp, input string tag);
        item_t it;
        #0.2;
        it = '{1, {31'b0, exp}, 32'h1, tag};
        sb.push_back(it);
        ->smp_ev;
        #0.2;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(8'h10, 0, 32'hFFFF_FFFF, "R1 enable");
        rd(8'h18, 0, 32'hFFFF_FFFF, "R1 mask");
        rd(8'h20, 0, 32'hFFFF_FFFF, "R1 type");
        rd(8'h2C, 0, 32'hFFFF_FFFF, "R1 polarity");
        rd(8'h30, 0, 32'hFFFF_FFFF, "R1 any-edge");
        rd(8'h58, 0, 32'hFFFF_FFFF, "R1 raw");
        rd(8'h50, 0, 32'hFFFF_FFFF, "R1 masked");
        irqc(1'b0, "R1 irq");

        // R10 start-up order
        wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h58, 32'hFFFF, 32'hFFFF_FFFF, "R6 raw records masked low level");
        rd(8'h5C, 32'hFFFF, 32'hFFFF_FFFF, "R6 raw upper half");
        rd(8'h50, 0, 32'hFFFF_FFFF, "R10 masked status");
        irqc(1'b0, "R10 irq");
        tick(2);
        irqc(1'b0, "R10 irq later");

        // R2 split halves with write enables
        wr(8'h20, 32'h00FF_ABCD);
        rd(8'h20, 32'h0000_00CD, 32'hFFFF_FFFF, "R2 partial enable");
        wr(8'h20, 32'hFF00_FFFF);
        rd(8'h20, 32'h0000_FFCD, 32'hFFFF_FFFF, "R2 other byte");
        wr(8'h24, 32'hFFFF_1234);
        rd(8'h24, 32'h0000_1234, 32'hFFFF_FFFF, "R2 upper half");
        rd(8'h20, 32'h0000_FFCD, 32'hFFFF_FFFF, "R2 lower half kept");
        rd(8'h10, 32'h0000_FFFF, 32'hFFFF_FFFF, "R2 other register kept");
        wr(8'h20, 32'hFFFF_0000); wr(8'h24, 32'hFFFF_0000);
        wr(8'h28, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h58, 0, 32'hFFFF_FFFF, "R3 high level with pins low");

        // R3 level sensing on pin 0, R9 timing
        wr(8'h18, 32'h0001_0000);
        pins[0] = 1'b1;
        rd(8'h58, 32'h1, 32'hFFFF, "R3 level follows pin");
        rd(8'h50, 32'h1, 32'hFFFF, "R6 unmasked shows");
        irqc(1'b0, "R9 not before clock");
        tick(1);
        irqc(1'b1, "R9 one clock later");
        pins[0] = 1'b0;
        rd(8'h58, 0, 32'hFFFF, "R3 level not held");
        tick(1);
        irqc(1'b0, "R9 drops");

        // R4 rising edge on pin 1
        wr(8'h20, 32'h0002_0002);
        wr(8'h18, 32'h0002_0000);
        pins[1] = 1'b1;
        rd(8'h58, 0, 32'h2, "R4 not before clock");
        tick(1);
        rd(8'h58, 32'h2, 32'h2, "R4 rising caught");
        irqc(1'b0, "R9 edge request delayed");
        tick(1);
        irqc(1'b1, "R9 edge request");
        pins[1] = 1'b0;
        tick(1);
        rd(8'h58, 32'h2, 32'h2, "R4 sticky after release");
        wr(8'h60, 32'h0002_0002);
        rd(8'h58, 0, 32'h2, "R7 acknowledge clears");
        rd(8'h60, 0, 32'hFFFF_FFFF, "R7 acknowledge reads zero");
        tick(1);
        irqc(1'b0, "R7 request gone");
        pins[1] = 1'b1;
        tick(2);
        wr(8'h60, 32'h0002_0002);
        pins[1] = 1'b0;
        tick(2);
        rd(8'h58, 0, 32'h2, "R4 falling ignored by rising pin");

        // R4 falling edge on pin 2
        wr(8'h20, 32'h0004_0004);
        wr(8'h28, 32'h0004_0000);
        pins[2] = 1'b1;
        tick(2);
        rd(8'h58, 0, 32'h4, "R4 rising ignored by falling pin");
        pins[2] = 1'b0;
        tick(1);
        rd(8'h58, 32'h4, 32'h4, "R4 falling caught");

        // R5 any-edge on pin 3 (type 0, polarity 1)
        wr(8'h30, 32'h0008_0008);
        pins[3] = 1'b1;
        tick(1);
        rd(8'h58, 32'h8, 32'h8, "R5 rise");
        wr(8'h60, 32'h0008_0008);
        rd(8'h58, 0, 32'h8, "R5 overrides high level");
        pins[3] = 1'b0;
        tick(1);
        rd(8'h58, 32'h8, 32'h8, "R5 fall");

        // R4 disabled pin 4
        wr(8'h10, 32'h0010_0000);
        wr(8'h20, 32'h0010_0010);
        pins[4] = 1'b1;
        tick(2);
        rd(8'h58, 0, 32'h10, "R4 disabled pin ignored");

        // R6 masked edge on pin 5
        wr(8'h20, 32'h0020_0020);
        wr(8'h60, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF);
        pins[5] = 1'b1;
        tick(1);
        rd(8'h58, 32'h20, 32'hFFFF, "R6 raw shows masked pin");
        rd(8'h50, 0, 32'hFFFF, "R6 masked status hides");
        tick(1);
        irqc(1'b0, "R6 no request");

        // R7 upper half on pin 20
        wr(8'h24, 32'h0010_0010);
        pins[20] = 1'b1;
        tick(1);
        rd(8'h5C, 32'h10, 32'h10, "R7 upper edge caught");
        wr(8'h60, 32'h0000_FFFF);
        rd(8'h5C, 32'h10, 32'h10, "R7 no enable no clear");
        wr(8'h64, 32'h0010_0010);
        rd(8'h5C, 0, 32'h10, "R7 upper clear");

        // R8 edge and acknowledge together on pin 1
        pins[1] = 1'b1;
        wr(8'h60, 32'h0002_0002);
        rd(8'h58, 32'h2, 32'h2, "R8 set wins");
        tick(1);
        irqc(1'b1, "R8 request follows");
        wr(8'h60, 32'h0002_0002);
        rd(8'h58, 0, 32'h2, "R8 later acknowledge clears");

        // R6 masking a pending pin
        pins[1] = 1'b0;
        tick(1);
        pins[1] = 1'b1;
        tick(1);
        rd(8'h58, 32'h2, 32'h2, "R4 new rise");
        wr(8'h18, 32'h0002_0002);
        rd(8'h50, 0, 32'h2, "R6 mask hides pending");
        rd(8'h58, 32'h2, 32'h2, "R6 raw keeps pending");
        tick(1);
        irqc(1'b0, "R6 request withdrawn");

        tick(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule